// File: doc/BRIEF.md
# Link-Layer Acknowledge and Replay Timers

This block runs the two timers of a serial packet link's data link layer. The acknowledge-latency timer starts when a packet arrives and, if no acknowledge has gone out by the deadline, raises a one-cycle request that forces one out. The replay timer starts when packets are sent and are still unacknowledged. If no acknowledge comes back in time, it raises a one-cycle request to retransmit.

Both deadlines are held in a timeout register. Software writes each field as the number of core-clock cycles at the full 125 MHz core rate. That number is (symbol-time timeout + L0s exit adjustment) × 125 / 250, since a symbol lasts 4 ns. The replay deadline uses the receiver L0s-to-L0 exit time. The acknowledge deadline uses the transmitter L0s exit time. A separate ratio register gives the real core clock as a fraction of 125 MHz, and the hardware scales both deadlines by it. The deadlines depend on the negotiated link width and the maximum payload size, so both registers may be rewritten while traffic is flowing.

Top module: `linkAckReplayTimers`

## Requirements
- R1: While `rstN` is low and after its release, `forceAck` and `replayReq` are low and both timers are idle. The ratio resets to 128, meaning full speed, so a deadline then equals its programmed field.
- R2: With `regAddr`=0, a write stores the acknowledge field from data bits 12..0 and the replay field from bits 26..13; bits 31..27 are ignored. With `regAddr`=1, a write stores the ratio from bits 7..0. Each effective deadline L is ceil(field × ratio / 128), and never less than 1.
- R3: When `pktRcvd` is sampled high at edge k while the acknowledge timer is idle, the timer starts. `forceAck` is then high in the cycle following edge k+L, where L is the acknowledge deadline.
- R4: `pktRcvd` seen while the acknowledge timer is already running neither restarts it nor moves its deadline.
- R5: `ackSent` stops the acknowledge timer with no pulse. It wins over an expiry or a `pktRcvd` at the same edge, and no `forceAck` follows until a new `pktRcvd`.
- R6: When `pktSent` is sampled at edge k with `outstanding` high while the replay timer is idle, the timer starts. `replayReq` is then high in the cycle following edge k+L, where L is the replay deadline.
- R7: `ackRcvd` sampled with `outstanding` high restarts the replay count from that edge.
- R8: Whenever `outstanding` is sampled low, the replay timer stops, with priority over every other event. `replayReq` is never high in the cycle after such an edge.
- R9: Each request is high for exactly one cycle. An expired timer stays idle and gives no further pulse until it is started again.
- R10: A deadline rewritten while a timer runs takes effect at once. If the new deadline is at or below the count already reached, the timer expires at the next edge.
- R11: `pktSent` seen while the replay timer is running does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects the timeout register, 1 selects the ratio register |
| regWrData | input | 32 | Register write data |
| pktRcvd | input | 1 | A packet was received |
| ackSent | input | 1 | An acknowledge was transmitted |
| pktSent | input | 1 | A packet was transmitted |
| ackRcvd | input | 1 | An acknowledge was received |
| outstanding | input | 1 | Unacknowledged packets exist |
| forceAck | output | 1 | One-cycle request to send an acknowledge |
| replayReq | output | 1 | One-cycle request to retransmit |

## Verification
A wrong run flag or count appears at the ports as a request pulse that comes early, comes late, repeats, or never comes. A timer that is wrongly running gives a pulse no later than one deadline after the fault. A timer that is wrongly idle never pulses, and that silence is checked over a window longer than the deadline. A mis-scaled deadline shifts the measured start-to-pulse distance by at least one cycle, and this is checked against hand-computed ceilings that include fractional and zero results.

// File: rtl/linkTmrPkg.sv
package linkTmrPkg;
  // Register select values on regAddr
  localparam logic SEL_TIMEOUT = 1'b0;
  localparam logic SEL_RATIO   = 1'b1;

  // Strobes from control to datapath
  typedef struct packed {
    logic ackLoad;
    logic ackStep;
    logic rplLoad;
    logic rplStep;
  } tmrCmd_t;
endpackage

// File: rtl/linkTmrCounter.sv
module linkTmrCounter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             step,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cnt <= '0;
    else if (load) cnt <= CNT_W'(1);
    else if (step) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/linkTmrDatapath.sv
module linkTmrDatapath
  import linkTmrPkg::*;
#(
  parameter int REG_W     = 32,
  parameter int ACK_W     = 13,
  parameter int RPL_W     = 14,
  parameter int RATIO_W   = 8,
  parameter int ACK_RST   = 255,
  parameter int RPL_RST   = 711,
  parameter int RATIO_RST = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  tmrCmd_t          cmd,
  output logic             ackDone,
  output logic             rplDone
);
  localparam int FRAC    = RATIO_W - 1;
  localparam int PROD_W  = RPL_W + RATIO_W;
  localparam int CNT_W   = PROD_W + 1 - FRAC;
  localparam int ROUND   = (2 ** FRAC) - 1;
  localparam int ACK_LSB = 0;
  localparam int RPL_LSB = ACK_LSB + ACK_W;
  localparam int USED_W  = RPL_LSB + RPL_W;

  logic [ACK_W-1:0]   ackField;
  logic [RPL_W-1:0]   rplField;
  logic [RATIO_W-1:0] ratio;
  logic               unusedRsvd;

  assign unusedRsvd = &regWrData[REG_W-1:USED_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackField <= ACK_W'(ACK_RST);
      rplField <= RPL_W'(RPL_RST);
      ratio    <= RATIO_W'(RATIO_RST);
    end else if (regWrEn) begin
      if (regAddr == SEL_TIMEOUT) begin
        ackField <= regWrData[ACK_LSB +: ACK_W];
        rplField <= regWrData[RPL_LSB +: RPL_W];
      end else begin
        ratio <= regWrData[RATIO_W-1:0];
      end
    end
  end

  logic [RPL_W-1:0] fieldSel [2];
  logic [1:0]       loadVec, stepVec, doneVec;

  assign fieldSel[0] = RPL_W'(ackField);
  assign fieldSel[1] = rplField;
  assign loadVec     = {cmd.rplLoad, cmd.ackLoad};
  assign stepVec     = {cmd.rplStep, cmd.ackStep};

  for (genvar gi = 0; gi < 2; gi++) begin : gTimer
    logic [PROD_W-1:0] prod;
    logic [PROD_W:0]   rounded;
    logic [CNT_W-1:0]  limRaw, lim, cnt;

    // Ceiling of field * ratio / 2^FRAC, floored at one cycle
    assign prod    = PROD_W'(fieldSel[gi]) * PROD_W'(ratio);
    assign rounded = {1'b0, prod} + (PROD_W+1)'(ROUND);
    assign limRaw  = rounded[PROD_W:FRAC];
    assign lim     = (limRaw == '0) ? CNT_W'(1) : limRaw;

    linkTmrCounter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .load (loadVec[gi]),
      .step (stepVec[gi]),
      .cnt  (cnt)
    );

    assign doneVec[gi] = (cnt >= lim);
  end

  assign ackDone = doneVec[0];
  assign rplDone = doneVec[1];
endmodule

// File: rtl/linkTmrCtrl.sv
module linkTmrCtrl
  import linkTmrPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pktRcvd,
  input  logic    ackSent,
  input  logic    pktSent,
  input  logic    ackRcvd,
  input  logic    outstanding,
  input  logic    ackDone,
  input  logic    rplDone,
  output tmrCmd_t cmd,
  output logic    forceAck,
  output logic    replayReq
);
  logic ackRun, rplRun;
  logic ackRunNext, rplRunNext, ackFire, rplFire;

  always_comb begin
    cmd        = '0;
    ackRunNext = ackRun;
    ackFire    = 1'b0;
    if (ackSent) begin
      ackRunNext = 1'b0;
    end else if (!ackRun && pktRcvd) begin
      cmd.ackLoad = 1'b1;
      ackRunNext  = 1'b1;
    end else if (ackRun && ackDone) begin
      ackRunNext = 1'b0;
      ackFire    = 1'b1;
    end else if (ackRun) begin
      cmd.ackStep = 1'b1;
    end

    rplRunNext = rplRun;
    rplFire    = 1'b0;
    if (!outstanding) begin
      rplRunNext = 1'b0;
    end else if (ackRcvd || (!rplRun && pktSent)) begin
      cmd.rplLoad = 1'b1;
      rplRunNext  = 1'b1;
    end else if (rplRun && rplDone) begin
      rplRunNext = 1'b0;
      rplFire    = 1'b1;
    end else if (rplRun) begin
      cmd.rplStep = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackRun    <= 1'b0;
      rplRun    <= 1'b0;
      forceAck  <= 1'b0;
      replayReq <= 1'b0;
    end else begin
      ackRun    <= ackRunNext;
      rplRun    <= rplRunNext;
      forceAck  <= ackFire;
      replayReq <= rplFire;
    end
  end
endmodule

// File: rtl/linkAckReplayTimers.sv
module linkAckReplayTimers
  import linkTmrPkg::*;
#(
  parameter int REG_W     = 32,
  parameter int ACK_W     = 13,
  parameter int RPL_W     = 14,
  parameter int RATIO_W   = 8,
  parameter int ACK_RST   = 255,
  parameter int RPL_RST   = 711,
  parameter int RATIO_RST = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             pktRcvd,
  input  logic             ackSent,
  input  logic             pktSent,
  input  logic             ackRcvd,
  input  logic             outstanding,
  output logic             forceAck,
  output logic             replayReq
);
  tmrCmd_t cmd;
  logic    ackDone, rplDone;

  linkTmrCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .pktRcvd     (pktRcvd),
    .ackSent     (ackSent),
    .pktSent     (pktSent),
    .ackRcvd     (ackRcvd),
    .outstanding (outstanding),
    .ackDone     (ackDone),
    .rplDone     (rplDone),
    .cmd         (cmd),
    .forceAck    (forceAck),
    .replayReq   (replayReq)
  );

  linkTmrDatapath #(
    .REG_W     (REG_W),
    .ACK_W     (ACK_W),
    .RPL_W     (RPL_W),
    .RATIO_W   (RATIO_W),
    .ACK_RST   (ACK_RST),
    .RPL_RST   (RPL_RST),
    .RATIO_RST (RATIO_RST)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .cmd       (cmd),
    .ackDone   (ackDone),
    .rplDone   (rplDone)
  );
endmodule

// File: rtl/linkTmrChk.sv
module linkTmrChk (
  input logic clk,
  input logic rstN,
  input logic ackSent,
  input logic outstanding,
  input logic forceAck,
  input logic replayReq
);
  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    forceAck |=> !forceAck);

  a_r9_rpl_single: assert property (@(posedge clk) disable iff (!rstN)
    replayReq |=> !replayReq);

  a_r5_ack_clear: assert property (@(posedge clk) disable iff (!rstN)
    ackSent |=> !forceAck);

  a_r8_no_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    !outstanding |=> !replayReq);

  a_r6_rpl_needs_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    $rose(replayReq) |-> $past(outstanding));
endmodule

bind linkAckReplayTimers linkTmrChk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .ackSent     (ackSent),
  .outstanding (outstanding),
  .forceAck    (forceAck),
  .replayReq   (replayReq)
);

// File: tb/linkAckReplayTimers_tb.sv
module linkAckReplayTimers_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic        pktRcvd = 1'b0, ackSent = 1'b0, pktSent = 1'b0, ackRcvd = 1'b0;
  logic        outstanding = 1'b0;
  logic        forceAck, replayReq;

  int total = 0, bad = 0;
  int cyc = 0;
  int ackPulses = 0, rplPulses = 0, ackAt = 0, rplAt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  linkAckReplayTimers u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .pktRcvd(pktRcvd), .ackSent(ackSent),
    .pktSent(pktSent), .ackRcvd(ackRcvd), .outstanding(outstanding),
    .forceAck(forceAck), .replayReq(replayReq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (forceAck)  begin ackPulses++; ackAt = cyc; end
    if (replayReq) begin rplPulses++; rplAt = cyc; end
  end

  // {field, ratio, expected deadline}
  localparam int NV = 7;
  localparam int VEC [NV][3] = '{
    '{10, 128, 10}, '{10, 64, 5}, '{7, 64, 4}, '{1, 1, 1},
    '{0, 128, 1},   '{20, 200, 32}, '{3, 255, 6}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic sel, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setFields(input int ackF, input int rplF);
    regWrite(1'b0, {5'b0, 14'(rplF), 13'(ackF)});
  endtask

  // 0 pktRcvd, 1 ackSent, 2 pktSent, 3 ackRcvd
  task automatic strobe(input int which);
    case (which)
      0: pktRcvd = 1'b1;
      1: ackSent = 1'b1;
      2: pktSent = 1'b1;
      default: ackRcvd = 1'b1;
    endcase
    @(negedge clk);
    pktRcvd = 1'b0; ackSent = 1'b0; pktSent = 1'b0; ackRcvd = 1'b0;
  endtask

  task automatic runAck(output int lat, output int pulses);
    int p0, s;
    p0 = ackPulses;
    strobe(0);
    s = cyc;
    idle(80);
    lat = ackAt - s;
    pulses = ackPulses - p0;
  endtask

  task automatic runRpl(output int lat, output int pulses);
    int p0, s;
    outstanding = 1'b1;
    p0 = rplPulses;
    strobe(2);
    s = cyc;
    idle(80);
    lat = rplAt - s;
    pulses = rplPulses - p0;
    outstanding = 1'b0;
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat, pulses, p0, s;
    idle(2);
    chk("R1 forceAck in reset", int'(forceAck), 0);
    chk("R1 replayReq in reset", int'(replayReq), 0);
    rstN = 1'b1;
    idle(5);
    chk("R1 forceAck after reset", int'(forceAck), 0);
    chk("R1 replayReq after reset", int'(replayReq), 0);
    chk("R1 no pulse after reset", ackPulses + rplPulses, 0);

    // R1 default ratio 128: deadline equals field
    setFields(6, 9);
    runAck(lat, pulses);
    chk("R1 default ratio ack", lat, 6);
    runRpl(lat, pulses);
    chk("R1 default ratio replay", lat, 9);

    // R2 R3 R6 R9 table of scaling cases
    for (int i = 0; i < NV; i++) begin
      setFields(VEC[i][0], VEC[i][0]);
      regWrite(1'b1, 32'(VEC[i][1]));
      runAck(lat, pulses);
      chk($sformatf("R2 R3 ack deadline vec%0d", i), lat, VEC[i][2]);
      chk($sformatf("R9 ack single pulse vec%0d", i), pulses, 1);
      runRpl(lat, pulses);
      chk($sformatf("R2 R6 replay deadline vec%0d", i), lat, VEC[i][2]);
      chk($sformatf("R9 replay single pulse vec%0d", i), pulses, 1);
    end

    regWrite(1'b1, 32'd128);
    // R2 reserved bits ignored: set bits 31..27 with fields 4/5
    regWrite(1'b0, {5'h1f, 14'd5, 13'd4});
    runAck(lat, pulses);
    chk("R2 reserved bits ack", lat, 4);
    runRpl(lat, pulses);
    chk("R2 reserved bits replay", lat, 5);

    setFields(10, 10);
    // R4 second packet while running
    p0 = ackPulses;
    strobe(0); s = cyc;
    idle(2); strobe(0);
    idle(40);
    chk("R4 no restart", ackAt - s, 10);
    chk("R4 one pulse", ackPulses - p0, 1);

    // R5 ackSent midway
    p0 = ackPulses;
    strobe(0); idle(3); strobe(1); idle(40);
    chk("R5 cleared no pulse", ackPulses - p0, 0);

    // R5 ackSent exactly at expiry edge (deadline 5)
    setFields(5, 10);
    p0 = ackPulses;
    strobe(0); idle(4); strobe(1); idle(40);
    chk("R5 clear beats expiry", ackPulses - p0, 0);

    // R5 ackSent and pktRcvd together while idle
    p0 = ackPulses;
    pktRcvd = 1'b1; ackSent = 1'b1;
    @(negedge clk);
    pktRcvd = 1'b0; ackSent = 1'b0;
    idle(40);
    chk("R5 clear beats start", ackPulses - p0, 0);

    // R10 shrink deadline mid-run (40 -> 5 at edge k+11)
    setFields(40, 10);
    p0 = ackPulses;
    strobe(0); s = cyc;
    idle(10);
    setFields(5, 10);
    idle(40);
    chk("R10 expiry after shrink", ackAt - s, 12);
    chk("R10 one pulse", ackPulses - p0, 1);

    setFields(10, 10);
    // R7 ackRcvd restarts at edge k+4 -> pulse at k+14
    outstanding = 1'b1;
    p0 = rplPulses;
    strobe(2); s = cyc;
    idle(3); strobe(3);
    idle(40);
    chk("R7 restart on ack", rplAt - s, 14);
    chk("R7 one pulse", rplPulses - p0, 1);

    // R11 pktSent while running
    p0 = rplPulses;
    strobe(2); s = cyc;
    idle(2); strobe(2);
    idle(40);
    chk("R11 no restart", rplAt - s, 10);
    chk("R11 one pulse", rplPulses - p0, 1);

    // R8 outstanding drops midway
    p0 = rplPulses;
    strobe(2); idle(3);
    outstanding = 1'b0;
    idle(40);
    chk("R8 clear midway", rplPulses - p0, 0);

    // R8 outstanding drops at the expiry edge
    outstanding = 1'b1;
    p0 = rplPulses;
    strobe(2); idle(9);
    outstanding = 1'b0;
    idle(40);
    chk("R8 clear beats expiry", rplPulses - p0, 0);
    chk("R8 replayReq low", int'(replayReq), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule